// File: doc/BRIEF.md
# DMA Block-Size Limit Counter

This block counts the transfers of one DMA logical channel that serves a USB endpoint, and marks where each block of transfers ends. Software writes a 16-bit control word that carries a channel enable, a stop-at-block flag and a 14-bit block size. The size is double buffered. A pending buffer holds the next size while an active counter counts down the current block, one step for each transfer acknowledge from the channel.

When the active count has reached zero, the next accepted acknowledge closes the block and raises an interrupt. If the stop-at-block flag is set, the channel then halts until software writes a new size. Otherwise the counter reloads from the buffer, and a one-cycle reload strobe tells the external address logic to switch to its next address at the same moment.

All pins are plain control and status signals. No data passes through the block, so it has no valid/ready stream interface and nothing that back-pressure applies to.

Top module: `dma_blk_counter`

## Requirements
- R1: After reset, `rd_data` is 0, and `irq`, `chan_active` and `reload_pulse` are all low.
- R2: A write (`wr_en` high) takes `wr_data[15]` as the enable and `wr_data[14]` as the stop-at-block flag. Both take effect from the next cycle and read back on `rd_data[15]` and `rd_data[14]`. `chan_active` is high when the enable is set and the channel is not halted.
- R3: The first write after reset or after a block boundary places `wr_data[13:0]` in the pending buffer only. The next write with no boundary in between loads its size into the active counter, and the buffer keeps the earlier value.
- R4: An accepted acknowledge is `ack` high with `chan_active` high and no write in the same cycle. Each accepted acknowledge with a nonzero count decrements the count by one. `rd_data[13:0]` shows the count as it stood after the most recent accepted acknowledge, and a write does not change it.
- R5: The acknowledge that brings the count to zero does not raise `irq`. The next accepted acknowledge, seen while the count is zero, is the block boundary and sets `irq`.
- R6: At a boundary with the stop flag clear, the active count is loaded from the buffer. `reload_pulse` is high for exactly the one cycle after that acknowledge.
- R7: At a boundary with the stop flag set, the count stays zero and no reload happens. `chan_active` drops and later acknowledges are ignored until the next write.
- R8: Any write clears `irq` and ends a halt. A write in the same cycle as `ack` takes priority, and that acknowledge is ignored.
- R9: While the enable bit is clear, acknowledges change neither the count nor `rd_data`.
- R10: A boundary that follows no new write reloads the same buffered size again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word: enable, stop flag, block size |
| rd_data | output | 16 | Enable, stop flag, count captured at the last acknowledge |
| ack | input | 1 | Transfer acknowledge from the channel |
| irq | output | 1 | Block-limit interrupt, held until the next write |
| chan_active | output | 1 | Channel enabled and not halted |
| reload_pulse | output | 1 | One-cycle strobe when the count reloads from the buffer |

## Verification
The bench first checks that the acknowledge which reaches zero leaves `irq` low and that only the following acknowledge raises it. A design that fires the interrupt early, or reloads one transfer too soon, shows the wrong count and interrupt state right there. It then runs a second boundary with no write in between, which catches a buffer that is consumed or cleared on reload. It also applies a write and an acknowledge in the same cycle, which catches a design that lets the acknowledge count. Finally it checks that acknowledges leave the count alone while the channel is halted by the stop flag or disabled, and that the two-write rule restarts after a boundary, so that a design that mixes up which register takes a write shows the wrong count.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int unsigned DBC_CNT_W = 14;

  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_DEC    = 2'd1,
    CNT_RELOAD = 2'd2,
    CNT_LOAD   = 2'd3
  } cnt_sel_e;
endpackage

// File: rtl/dbc_buf.sv
module dbc_buf #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_size,
  input  logic         bound,
  output logic [W-1:0] buf_q,
  output logic         second_wr
);
  logic pend_q;

  // a write while a first write is still pending goes to the active counter
  assign second_wr = wr_en & pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      pend_q <= 1'b0;
    end else if (wr_en) begin
      if (!pend_q) begin
        buf_q  <= wr_size;
        pend_q <= 1'b1;
      end else begin
        pend_q <= 1'b0;
      end
    end else if (bound) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dbc_count.sv
module dbc_count
  import dbc_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_sel_e     sel,
  input  logic         acc,
  input  logic [W-1:0] wr_size,
  input  logic [W-1:0] buf_size,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] snap_q
);
  logic [W-1:0] cnt_nxt;

  always_comb begin
    unique case (sel)
      CNT_DEC:    cnt_nxt = cnt_q - W'(1);
      CNT_RELOAD: cnt_nxt = buf_size;
      CNT_LOAD:   cnt_nxt = wr_size;
      default:    cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (acc) snap_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/dbc_ctrl.sv
module dbc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_enable,
  input  logic wr_stop,
  input  logic ack,
  input  logic cnt_zero,
  output logic en_q,
  output logic stop_q,
  output logic halt_q,
  output logic irq_q,
  output logic reload_q,
  output logic acc,
  output logic dec,
  output logic bound,
  output logic reload
);
  assign acc    = ack & ~wr_en & en_q & ~halt_q;
  assign dec    = acc & ~cnt_zero;
  assign bound  = acc & cnt_zero;
  assign reload = bound & ~stop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      stop_q   <= 1'b0;
      halt_q   <= 1'b0;
      irq_q    <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      reload_q <= reload;
      if (wr_en) begin
        en_q   <= wr_enable;
        stop_q <= wr_stop;
        halt_q <= 1'b0;
        irq_q  <= 1'b0;
      end else if (bound) begin
        irq_q <= 1'b1;
        if (stop_q) halt_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_blk_counter.sv
module dma_blk_counter
  import dbc_pkg::*;
#(
  parameter int unsigned CNT_W = DBC_CNT_W,
  localparam int unsigned REG_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             ack,
  output logic             irq,
  output logic             chan_active,
  output logic             reload_pulse
);
  logic [CNT_W-1:0] buf_q, cnt_q, snap_q;
  logic second_wr, en_q, stop_q, halt_q, irq_q, reload_q;
  logic acc, dec, bound, reload;
  cnt_sel_e sel;

  dbc_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_enable(wr_data[CNT_W+1]), .wr_stop(wr_data[CNT_W]),
    .ack(ack), .cnt_zero(cnt_q == '0),
    .en_q(en_q), .stop_q(stop_q), .halt_q(halt_q), .irq_q(irq_q),
    .reload_q(reload_q), .acc(acc), .dec(dec), .bound(bound), .reload(reload)
  );

  dbc_buf #(.W(CNT_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_size(wr_data[CNT_W-1:0]),
    .bound(bound), .buf_q(buf_q), .second_wr(second_wr)
  );

  always_comb begin
    if (second_wr)   sel = CNT_LOAD;
    else if (dec)    sel = CNT_DEC;
    else if (reload) sel = CNT_RELOAD;
    else             sel = CNT_HOLD;
  end

  dbc_count #(.W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .acc(acc),
    .wr_size(wr_data[CNT_W-1:0]), .buf_size(buf_q),
    .cnt_q(cnt_q), .snap_q(snap_q)
  );

  assign rd_data      = {en_q, stop_q, snap_q};
  assign irq          = irq_q;
  assign chan_active  = en_q & ~halt_q;
  assign reload_pulse = reload_q;
endmodule

// File: rtl/dbc_chk.sv
module dbc_chk #(
  parameter int unsigned W = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         ack,
  input logic [W+1:0] rd_data,
  input logic         irq,
  input logic         chan_active,
  input logic         reload_pulse,
  input logic [W-1:0] cnt
);
  AST_WR_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !irq); // R8

  AST_DEC_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en && chan_active && cnt != '0) |=> cnt == W'($past(cnt) - W'(1))); // R4

  AST_IRQ_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en && chan_active && cnt == '0) |=> irq); // R5

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en && chan_active && cnt == '0 && rd_data[W]) |=> (!chan_active && !reload_pulse)); // R7

  AST_RELOAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en && chan_active && cnt == '0 && !rd_data[W]) |=> reload_pulse); // R6

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_active && !wr_en) |=> ($stable(rd_data) && $stable(cnt) && !reload_pulse)); // R9
endmodule

bind dma_blk_counter dbc_chk #(.W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ack(ack), .rd_data(rd_data),
  .irq(irq), .chan_active(chan_active), .reload_pulse(reload_pulse), .cnt(cnt_q)
);

// File: tb/dma_blk_counter_tb_top.sv
module dma_blk_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic ack = 1'b0;
  logic [15:0] rd_data;
  logic irq, chan_active, reload_pulse;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int          stamp;
    string       req;
    logic [15:0] rd;
    logic        irq;
    logic        act;
    logic        rl;
  } exp_t;
  exp_t sb[$];
  exp_t it;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_blk_counter dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ack(ack), .irq(irq),
    .chan_active(chan_active), .reload_pulse(reload_pulse)
  );

  // monitor: compares the outputs at the falling edge of the cycle an item is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].stamp == cyc) begin
      it = sb.pop_front();
      n_vec++;
      if (rd_data !== it.rd || irq !== it.irq || chan_active !== it.act || reload_pulse !== it.rl) begin
        n_bad++;
        $display("FAIL %s: rd=%h irq=%b act=%b rl=%b, expected rd=%h irq=%b act=%b rl=%b",
                 it.req, rd_data, irq, chan_active, reload_pulse, it.rd, it.irq, it.act, it.rl);
      end
    end
  end

  task automatic step(input logic w, input logic [15:0] d, input logic a);
    @(posedge clk);
    #1;
    wr_en = w; wr_data = d; ack = a;
  endtask

  // expected outputs after the most recently driven step has been clocked in
  task automatic expect_out(input string req, input logic [15:0] rd, input logic i,
                            input logic act, input logic rl);
    exp_t e;
    e.stamp = cyc + 1; e.req = req; e.rd = rd; e.irq = i; e.act = act; e.rl = rl;
    sb.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(0, 16'h0000, 0); expect_out("R1", 16'h0000, 0, 0, 0);
    // first write fills the buffer (size 3), enable set
    step(1, 16'h8003, 0); expect_out("R2", 16'h8000, 0, 1, 0);
    // second write loads active count 2
    step(1, 16'h8002, 0); expect_out("R3", 16'h8000, 0, 1, 0);
    step(0, 16'h0000, 1); expect_out("R4", 16'h8001, 0, 1, 0);
    step(0, 16'h0000, 1); expect_out("R5", 16'h8000, 0, 1, 0);
    // boundary: irq, reload from buffer 3
    step(0, 16'h0000, 1); expect_out("R6", 16'h8003, 1, 1, 1);
    step(0, 16'h0000, 0); expect_out("R6", 16'h8003, 1, 1, 0);
    step(0, 16'h0000, 1); expect_out("R4", 16'h8002, 1, 1, 0);
    step(0, 16'h0000, 1); expect_out("R4", 16'h8001, 1, 1, 0);
    step(0, 16'h0000, 1); expect_out("R5", 16'h8000, 1, 1, 0);
    // second boundary without a new write reloads 3 again
    step(0, 16'h0000, 1); expect_out("R10", 16'h8003, 1, 1, 1);
    // write with simultaneous ack: irq cleared, ack ignored, buffer=2, stop set
    step(1, 16'hC002, 1); expect_out("R8", 16'hC003, 0, 1, 0);
    step(0, 16'h0000, 1); expect_out("R4", 16'hC002, 0, 1, 0);
    step(0, 16'h0000, 1); expect_out("R4", 16'hC001, 0, 1, 0);
    step(0, 16'h0000, 1); expect_out("R5", 16'hC000, 0, 1, 0);
    // boundary with stop set: halt, no reload
    step(0, 16'h0000, 1); expect_out("R7", 16'hC000, 1, 0, 0);
    step(0, 16'h0000, 1); expect_out("R7", 16'hC000, 1, 0, 0);
    // write ends halt and clears irq; first write after boundary -> buffer only
    step(1, 16'hC005, 0); expect_out("R8", 16'hC000, 0, 1, 0);
    step(0, 16'h0000, 0); expect_out("R3", 16'hC000, 0, 1, 0);
    // second write loads count 4 and clears enable
    step(1, 16'h4004, 0); expect_out("R2", 16'h4000, 0, 0, 0);
    step(0, 16'h0000, 1); expect_out("R9", 16'h4000, 0, 0, 0);
    step(0, 16'h0000, 1); expect_out("R9", 16'h4000, 0, 0, 0);
    // first write again (buffer 7), count still 4
    step(1, 16'h8007, 0); expect_out("R3", 16'h8000, 0, 1, 0);
    step(0, 16'h0000, 1); expect_out("R3", 16'h8003, 0, 1, 0);
    step(0, 16'h0000, 0);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule